// File: doc/BRIEF.md
# LCD Controller Register File

This block is the software-visible register space of a colour LCD controller. A simple 32-bit bus reaches it through a 4 KB byte-addressed window; each register takes one word. The window holds four panel timing words, two frame base addresses, a control word, an interrupt mask, a raw interrupt status word with a write-one-to-clear port, and a read-only identification area. A block of addresses is passed straight through to an external colour palette store.

The block decodes the panel size from packed timing fields. It also decodes the enable and pixel-depth fields from the control word and presents all of these as plain outputs for the video pipeline. Interrupt events arrive as single-cycle pulses on `irq_src`. They set bits in the raw status, and `irq` is high while any unmasked status bit is set. Every bus write raises `reconfig` for one cycle so that downstream logic knows to redraw. The parameter `VARIANT` selects between three layouts: 0 is the base layout, 1 swaps the control and mask addresses, and 2 swaps them and also reports the extended identification bytes.

Writes take effect at the clock edge on which `wr_en` is high. `rd_data` is a combinational function of `addr` and of the register state. The bus has no back-pressure: every access completes in its own cycle.

Top module: `lcd_regfile`

## Requirements
- R1: Offsets 0x000 to 0x00C hold timing words 0 to 3, offset 0x010 holds the upper frame base and 0x014 holds the lower frame base, each a full 32-bit read/write register. Offsets 0x02C and 0x030 read back the upper and lower base as current-address values.
- R2: With VARIANT 0 the interrupt mask (NIRQ bits, upper bits read 0) sits at 0x018 and the control word at 0x01C. With VARIANT 1 or 2 the two are exchanged for both reads and writes.
- R3: A 1 on bit i of `irq_src` at a clock edge sets raw status bit i. Offset 0x020 reads the raw status and offset 0x024 reads the raw status ANDed with the mask.
- R4: A write to 0x028 clears each raw status bit written as 1. When a clear and a source pulse hit the same bit in the same cycle, the bit ends up set.
- R5: `cols` equals (timing0[7:2] + 1) × 16 and `rows` equals timing1[9:0] + 1. Both follow the register on the cycle after the write.
- R6: `enabled` is high only when control bit 0 and control bit 11 are both 1. `bpp` equals control bits [3:1].
- R7: A read at 0xFE0 + 4·k (k = 0..7) returns identification byte k in bits [7:0], with zeros above. For VARIANT 0 and 1 the bytes are 10 11 04 00 0D F0 05 B1. For VARIANT 2 they are 11 11 24 00 0D F0 05 B1. Writes there change nothing.
- R8: `irq` is high exactly when the masked status is non-zero.
- R9: Reads of 0x028, of 0x034 to 0x1FC and of 0x400 to 0xFDC return 0. Writes to them, and writes to 0x02C and 0x030, leave every register unchanged.
- R10: `reconfig` is high for exactly the one cycle that follows each cycle with `wr_en` high, at any address.
- R11: For offsets 0x200 to 0x3FC, `pal_we` follows `wr_en` and `pal_idx` equals offset bits [8:2], and `rd_data` returns `pal_rd_data`. Outside that range `pal_we` stays low.
- R12: Reset (active-low, synchronous) clears every register. After reset `cols` is 16, `rows` is 1, and `enabled`, `irq` and `reconfig` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe for the current address |
| addr | input | 12 | Byte address within the window (bits [1:0] ignored) |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data for `addr` (combinational) |
| irq_src | input | NIRQ | Interrupt event pulses, one per status bit |
| irq | output | 1 | Masked interrupt request |
| pal_we | output | 1 | Write strobe to the external palette store |
| pal_idx | output | 7 | Palette word index |
| pal_rd_data | input | 32 | Read data from the palette store |
| cols | output | 11 | Active pixels per line |
| rows | output | 11 | Active lines per frame |
| enabled | output | 1 | Controller enabled and powered |
| bpp | output | 3 | Pixel depth code from control |
| reconfig | output | 1 | One-cycle pulse after any write |

## Verification
Two things can reach the raw status in the same cycle: a source pulse setting a bit and a software clear writing to 0x028. The bench provokes this by raising `irq_src` during the very cycle of a clear write, on the same bit and on a different bit. It then judges the result from the raw and masked read-back and from `irq` in the following cycle, against a model in which set takes priority. The swapped control/mask layout is driven in parallel on a second instance, so that the same write stream lands in different registers of the two instances.

// File: rtl/lcdr_pkg.sv
package lcdr_pkg;
  localparam int HFLD_LSB = 2;
  localparam int HFLD_W   = 6;
  localparam int VFLD_W   = 10;
  localparam int COL_SHIFT = 4;
  localparam int CTL_EN_BIT  = 0;
  localparam int CTL_PWR_BIT = 11;
  localparam int CTL_BPP_LSB = 1;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_TIM, SEL_UBASE, SEL_LBASE, SEL_MASK, SEL_CTRL,
    SEL_RAW, SEL_MSTAT, SEL_CLR, SEL_UCUR, SEL_LCUR, SEL_PAL, SEL_ID
  } sel_e;

  function automatic logic [7:0] id_byte(int variant, logic [2:0] k);
    logic [7:0] b;
    case (k)
      3'd0: b = (variant == 2) ? 8'h11 : 8'h10;
      3'd1: b = 8'h11;
      3'd2: b = (variant == 2) ? 8'h24 : 8'h04;
      3'd3: b = 8'h00;
      3'd4: b = 8'h0D;
      3'd5: b = 8'hF0;
      3'd6: b = 8'h05;
      default: b = 8'hB1;
    endcase
    return b;
  endfunction
endpackage

// File: rtl/lcdr_decode.sv
module lcdr_decode
  import lcdr_pkg::*;
#(
  parameter int VARIANT = 0,
  parameter int ADDR_W  = 12
) (
  input  logic [ADDR_W-1:0] addr,
  output sel_e              sel,
  output logic [1:0]        tidx
);
  localparam bit SWAP = (VARIANT != 0);

  always_comb begin
    sel  = SEL_NONE;
    tidx = addr[3:2];
    if (addr[ADDR_W-1:5] == '1) begin
      sel = SEL_ID;
    end else if (addr[ADDR_W-1:9] == 3'b001) begin
      sel = SEL_PAL;
    end else if (addr[ADDR_W-1:6] == '0) begin
      case (addr[5:2])
        4'd0, 4'd1, 4'd2, 4'd3: sel = SEL_TIM;
        4'd4:  sel = SEL_UBASE;
        4'd5:  sel = SEL_LBASE;
        4'd6:  sel = SWAP ? SEL_CTRL : SEL_MASK;
        4'd7:  sel = SWAP ? SEL_MASK : SEL_CTRL;
        4'd8:  sel = SEL_RAW;
        4'd9:  sel = SEL_MSTAT;
        4'd10: sel = SEL_CLR;
        4'd11: sel = SEL_UCUR;
        4'd12: sel = SEL_LCUR;
        default: sel = SEL_NONE;
      endcase
    end
  end
endmodule

// File: rtl/lcdr_irq.sv
module lcdr_irq #(
  parameter int NIRQ = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            mask_we,
  input  logic            clr_we,
  input  logic [NIRQ-1:0] wdata,
  input  logic [NIRQ-1:0] src,
  output logic [NIRQ-1:0] mask,
  output logic [NIRQ-1:0] raw,
  output logic            irq
);
  logic [NIRQ-1:0] clr_bits;
  assign clr_bits = clr_we ? wdata : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask <= '0;
      raw  <= '0;
    end else begin
      if (mask_we) mask <= wdata;
      raw <= (raw & ~clr_bits) | src;
    end
  end

  assign irq = |(raw & mask);
endmodule

// File: rtl/lcdr_geom.sv
module lcdr_geom
  import lcdr_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int GEOM_W = 11
) (
  input  logic [DATA_W-1:0] tim0,
  input  logic [DATA_W-1:0] tim1,
  input  logic [DATA_W-1:0] ctrl,
  output logic [GEOM_W-1:0] cols,
  output logic [GEOM_W-1:0] rows,
  output logic              enabled,
  output logic [2:0]        bpp
);
  logic [GEOM_W-1:0] hfld;
  logic [GEOM_W-1:0] vfld;

  assign hfld    = GEOM_W'(tim0[HFLD_LSB +: HFLD_W]);
  assign vfld    = GEOM_W'(tim1[VFLD_W-1:0]);
  assign cols    = (hfld + GEOM_W'(1)) << COL_SHIFT;
  assign rows    = vfld + GEOM_W'(1);
  assign enabled = ctrl[CTL_EN_BIT] & ctrl[CTL_PWR_BIT];
  assign bpp     = ctrl[CTL_BPP_LSB +: 3];
endmodule

// File: rtl/lcd_regfile.sv
module lcd_regfile
  import lcdr_pkg::*;
#(
  parameter int VARIANT   = 0,
  parameter int NIRQ      = 4,
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 12,
  parameter int PAL_IDX_W = 7,
  parameter int GEOM_W    = 11
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [DATA_W-1:0]    wr_data,
  output logic [DATA_W-1:0]    rd_data,
  input  logic [NIRQ-1:0]      irq_src,
  output logic                 irq,
  output logic                 pal_we,
  output logic [PAL_IDX_W-1:0] pal_idx,
  input  logic [DATA_W-1:0]    pal_rd_data,
  output logic [GEOM_W-1:0]    cols,
  output logic [GEOM_W-1:0]    rows,
  output logic                 enabled,
  output logic [2:0]           bpp,
  output logic                 reconfig
);
  localparam int NTIM = 4;

  sel_e            sel;
  logic [1:0]      tidx;
  logic [DATA_W-1:0] tim [NTIM];
  logic [DATA_W-1:0] ubase, lbase, ctrl;
  logic [NIRQ-1:0] mask, raw;

  lcdr_decode #(.VARIANT(VARIANT), .ADDR_W(ADDR_W)) u_dec (
    .addr(addr), .sel(sel), .tidx(tidx)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NTIM; i++) tim[i] <= '0;
      ubase    <= '0;
      lbase    <= '0;
      ctrl     <= '0;
      reconfig <= 1'b0;
    end else begin
      reconfig <= wr_en;
      if (wr_en) begin
        case (sel)
          SEL_TIM:   tim[tidx] <= wr_data;
          SEL_UBASE: ubase     <= wr_data;
          SEL_LBASE: lbase     <= wr_data;
          SEL_CTRL:  ctrl      <= wr_data;
          default: ;
        endcase
      end
    end
  end

  lcdr_irq #(.NIRQ(NIRQ)) u_irq (
    .clk(clk), .rst_n(rst_n),
    .mask_we(wr_en && sel == SEL_MASK),
    .clr_we(wr_en && sel == SEL_CLR),
    .wdata(wr_data[NIRQ-1:0]),
    .src(irq_src),
    .mask(mask), .raw(raw), .irq(irq)
  );

  lcdr_geom #(.DATA_W(DATA_W), .GEOM_W(GEOM_W)) u_geom (
    .tim0(tim[0]), .tim1(tim[1]), .ctrl(ctrl),
    .cols(cols), .rows(rows), .enabled(enabled), .bpp(bpp)
  );

  assign pal_we  = wr_en && (sel == SEL_PAL);
  assign pal_idx = addr[PAL_IDX_W+1:2];

  always_comb begin
    case (sel)
      SEL_TIM:   rd_data = tim[tidx];
      SEL_UBASE, SEL_UCUR: rd_data = ubase;
      SEL_LBASE, SEL_LCUR: rd_data = lbase;
      SEL_CTRL:  rd_data = ctrl;
      SEL_MASK:  rd_data = DATA_W'(mask);
      SEL_RAW:   rd_data = DATA_W'(raw);
      SEL_MSTAT: rd_data = DATA_W'(raw & mask);
      SEL_PAL:   rd_data = pal_rd_data;
      SEL_ID:    rd_data = DATA_W'(id_byte(VARIANT, addr[4:2]));
      default:   rd_data = '0;
    endcase
  end
endmodule

// File: rtl/lcdr_checker.sv
module lcdr_checker #(
  parameter int NIRQ   = 4,
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int GEOM_W = 11
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wr_data,
  input logic [NIRQ-1:0]   irq_src,
  input logic              irq,
  input logic              reconfig,
  input logic [GEOM_W-1:0] cols,
  input logic [GEOM_W-1:0] rows,
  input logic              enabled,
  input logic              pal_we
);
  AST_RECONF_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n) wr_en |=> reconfig); // R10
  AST_RECONF_ONLY_WRITE: assert property (@(posedge clk) disable iff (!rst_n) !wr_en |=> !reconfig); // R10
  AST_GEOM_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !wr_en |=> ($stable(cols) && $stable(rows))); // R5
  AST_EN_FALL_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n) $fell(enabled) |-> $past(wr_en)); // R6
  AST_CLEAR_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 12'h028 && (&wr_data[NIRQ-1:0]) && irq_src == '0) |=> !irq); // R4
  AST_PAL_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n) pal_we |-> (wr_en && addr[ADDR_W-1:9] == 3'b001)); // R11
endmodule

bind lcd_regfile lcdr_checker #(.NIRQ(NIRQ), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .GEOM_W(GEOM_W)) u_chk (.*);

// File: tb/lcd_regfile_test.sv
`timescale 1ns/1ps
module lcd_regfile_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wr_data = '0;
  logic [3:0]  irq_src = '0;
  logic [31:0] pal_rd_data = 32'hA5A5_0000;
  logic [31:0] rd [2];
  logic        irq [2], pal_we [2], en [2], rc [2];
  logic [6:0]  pidx [2];
  logic [10:0] cols [2], rows [2];
  logic [2:0]  bpp [2];

  always #2 clk = ~clk;

  lcd_regfile #(.VARIANT(0)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .rd_data(rd[0]), .irq_src(irq_src), .irq(irq[0]), .pal_we(pal_we[0]),
    .pal_idx(pidx[0]), .pal_rd_data(pal_rd_data), .cols(cols[0]), .rows(rows[0]),
    .enabled(en[0]), .bpp(bpp[0]), .reconfig(rc[0]));
  lcd_regfile #(.VARIANT(2)) uut_x (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .rd_data(rd[1]), .irq_src(irq_src), .irq(irq[1]), .pal_we(pal_we[1]),
    .pal_idx(pidx[1]), .pal_rd_data(pal_rd_data), .cols(cols[1]), .rows(rows[1]),
    .enabled(en[1]), .bpp(bpp[1]), .reconfig(rc[1]));

  // behavioural reference: index 0 = base layout, index 1 = swapped + extended id
  int unsigned m_tim [2][4];
  int unsigned m_ub [2], m_lb [2], m_ctl [2], m_msk [2], m_raw [2];
  bit m_rc [2];
  bit started = 0;
  int vectors = 0, fails = 0;
  string cur_req = "R12";
  bit done = 0;

  function automatic int unsigned id_exp(int k, int n);
    byte unsigned t [8] = '{8'h10, 8'h11, 8'h04, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
    if (k == 1 && n == 0) return 32'h11;
    if (k == 1 && n == 2) return 32'h24;
    return t[n];
  endfunction

  function automatic int unsigned mread(int k, int unsigned a);
    a = a & 32'hFFC;
    if (a >= 32'hFE0) return id_exp(k, (a - 32'hFE0) / 4);
    if (a >= 32'h200 && a < 32'h400) return pal_rd_data;
    if (a < 32'h10) return m_tim[k][a/4];
    if (a == 32'h10 || a == 32'h2C) return m_ub[k];
    if (a == 32'h14 || a == 32'h30) return m_lb[k];
    if (a == 32'h18) return (k == 0) ? m_msk[k] : m_ctl[k];
    if (a == 32'h1C) return (k == 0) ? m_ctl[k] : m_msk[k];
    if (a == 32'h20) return m_raw[k];
    if (a == 32'h24) return m_raw[k] & m_msk[k];
    return 0;
  endfunction

  always @(posedge clk) begin
    for (int k = 0; k < 2; k++) begin
      if (!rst_n) begin
        for (int i = 0; i < 4; i++) m_tim[k][i] = 0;
        m_ub[k] = 0; m_lb[k] = 0; m_ctl[k] = 0; m_msk[k] = 0; m_raw[k] = 0; m_rc[k] = 0;
      end else begin
        int unsigned a;
        a = addr & 12'hFFC;
        m_rc[k] = wr_en;
        if (wr_en && a == 32'h28) m_raw[k] = m_raw[k] & ~(wr_data & 32'hF);
        m_raw[k] = m_raw[k] | irq_src;
        if (wr_en) begin
          if (a < 32'h10) m_tim[k][a/4] = wr_data;
          else if (a == 32'h10) m_ub[k] = wr_data;
          else if (a == 32'h14) m_lb[k] = wr_data;
          else if ((a == 32'h18) == (k == 0) && (a == 32'h18 || a == 32'h1C)) m_msk[k] = wr_data & 32'hF;
          else if (a == 32'h18 || a == 32'h1C) m_ctl[k] = wr_data;
        end
      end
    end
    started = 1;
  end

  task automatic cmp(string what, string req, int unsigned act, int unsigned exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) if (started && !done) begin
    for (int k = 0; k < 2; k++) begin
      int unsigned a;
      bit inpal;
      a = addr & 12'hFFC;
      inpal = (a >= 32'h200 && a < 32'h400);
      cmp("rd_data", cur_req, rd[k], mread(k, a));
      cmp("cols", "R5", cols[k], ((m_tim[k][0] >> 2) % 64 + 1) * 16);
      cmp("rows", "R5", rows[k], m_tim[k][1] % 1024 + 1);
      cmp("enabled", "R6", en[k], (m_ctl[k] & 1) & ((m_ctl[k] >> 11) & 1));
      cmp("bpp", "R6", bpp[k], (m_ctl[k] >> 1) & 7);
      cmp("irq", "R8", irq[k], ((m_raw[k] & m_msk[k]) != 0));
      cmp("reconfig", "R10", rc[k], m_rc[k]);
      cmp("pal_we", "R11", pal_we[k], wr_en && inpal);
      if (inpal) cmp("pal_idx", "R11", pidx[k], (a >> 2) % 128);
    end
  end

  task automatic step(bit w, int unsigned a, int unsigned d, int unsigned s);
    @(posedge clk); #1;
    wr_en = w; addr = a[11:0]; wr_data = d; irq_src = s[3:0];
    pal_rd_data = 32'hA5A5_0000 | a;
  endtask

  task automatic rdall();
    for (int a = 0; a <= 32'h34; a += 4) step(0, a, 0, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    cur_req = "R12"; step(0, 0, 0, 0); rst_n = 1; rdall();
    cur_req = "R1";
    step(1, 32'h00, 32'h1234_5678, 0); step(1, 32'h04, 32'h0000_0ABC, 0);
    step(1, 32'h08, 32'hDEAD_BEEF, 0); step(1, 32'h0C, 32'h0F0F_0F0F, 0);
    step(1, 32'h10, 32'h8000_0000, 0); step(1, 32'h14, 32'h0010_0000, 0); rdall();
    cur_req = "R5";
    step(1, 32'h00, 32'h0000_00FC, 0); step(1, 32'h04, 32'h0000_03FF, 0); step(0, 0, 0, 0);
    step(1, 32'h00, 32'hFFFF_FF28, 0); step(1, 32'h04, 32'hFFFF_F1DF, 0); step(0, 4, 0, 0);
    cur_req = "R2";
    step(1, 32'h1C, 32'h0000_0801, 0); step(1, 32'h18, 32'h0000_000F, 0); rdall();
    cur_req = "R6";
    step(1, 32'h1C, 32'h0000_0001, 0); step(1, 32'h18, 32'h0000_0800, 0); step(0, 32'h1C, 0, 0);
    step(1, 32'h1C, 32'h0000_080B, 0); step(1, 32'h18, 32'h0000_0805, 0); step(0, 32'h18, 0, 0);
    cur_req = "R3";
    step(1, 32'h18, 32'h0000_0005, 0); step(1, 32'h1C, 32'h0000_0005, 0);
    step(0, 32'h20, 0, 1); step(0, 32'h20, 0, 0); step(0, 32'h24, 0, 2); step(0, 32'h24, 0, 8);
    step(0, 32'h20, 0, 0);
    cur_req = "R4";
    step(1, 32'h28, 32'h1, 1); step(0, 32'h20, 0, 0); step(0, 32'h24, 0, 0);
    step(1, 32'h28, 32'h2, 4); step(0, 32'h20, 0, 0);
    step(1, 32'h28, 32'hF, 0); step(0, 32'h20, 0, 0); step(0, 32'h24, 0, 0);
    step(0, 32'h20, 0, 4); step(1, 32'h28, 32'hFFFF_FFFF, 0); step(0, 32'h24, 0, 0);
    cur_req = "R9";
    step(0, 32'h28, 0, 0); step(0, 32'h34, 0, 0); step(0, 32'h1FC, 0, 0);
    step(0, 32'h400, 0, 0); step(0, 32'hFDC, 0, 0);
    step(1, 32'h34, 32'hFFFF_FFFF, 0); step(1, 32'h400, 32'hFFFF_FFFF, 0);
    step(1, 32'h2C, 32'h1111_1111, 0); step(1, 32'h30, 32'h2222_2222, 0); rdall();
    cur_req = "R7";
    for (int a = 32'hFE0; a <= 32'hFFC; a += 4) step(0, a, 0, 0);
    step(1, 32'hFE0, 32'hFF, 0); step(0, 32'hFE0, 0, 0);
    cur_req = "R11";
    step(1, 32'h200, 32'h7FFF, 0); step(1, 32'h3FC, 32'h1234, 0); step(0, 32'h204, 0, 0);
    step(0, 32'h3FC, 0, 0);
    cur_req = "R10";
    step(1, 32'h08, 32'h1, 0); step(1, 32'h08, 32'h2, 0); step(0, 32'h08, 0, 0); step(0, 0, 0, 0);
    cur_req = "R12";
    rst_n = 0; step(0, 0, 0, 0); step(0, 0, 0, 0); rst_n = 1; rdall();
    @(posedge clk); done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    #(100000 * 4);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule